// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block issues single management transactions on a two-wire serial PHY management bus. A client presents a direction bit, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It then pulses `start`. The block builds a 64-bit frame and clocks it out bit by bit. The frame holds 32 ones, a start pattern, an opcode, both addresses, a two-bit turnaround and a 16-bit data field. The management clock is made from the system clock by a fixed divider. While the block is working it holds `busy` high. It ends each transaction with a one-cycle `done` pulse.

On writes the master drives every bit, including the turnaround. It releases the line once the frame ends. On reads it stops driving after the register address. It expects the PHY to drive the second turnaround bit low, and it then shifts in the PHY's 16 data bits. If that turnaround bit does not come back low, the read is flagged as failed and the returned data is forced to all ones. The pad tristate cell sits outside the block: it sees only an output value, an output enable and the sampled input.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc`, `mdioOe`, `rdErr` are 0 and `rdData` is 0x0000; whenever `busy` is 0, `mdioOe` and `mdc` are 0.
- R2: Every frame is 64 bits long. Frame bits 0..31 (in transmit order) are ones, and bits 32..33 are the start pattern 0 then 1.
- R3: Frame bits 34..35 carry the opcode: 0,1 for a write (`isRead`=0) and 1,0 for a read (`isRead`=1). Bits 36..40 carry `phyAddr` and bits 41..45 carry `regAddr`, each MSB first.
- R4: On a write, `mdioOe` is 1 for all 64 bits. Bits 46..47 are 1 then 0, and bits 48..63 are `wrData` MSB first. `mdioOe` is 0 once `done` has pulsed.
- R5: On a read, `mdioOe` is 1 for bits 0..45 and 0 from bit 46 to the end of the frame.
- R6: On a read whose bit 47 is sampled as 0, the block samples bits 48..63 into `rdData`, MSB first, and clears `rdErr`.
- R7: On a read whose bit 47 is sampled as 1, `rdErr` is set and `rdData` is 0xFFFF.
- R8: `mdioOut` changes only on the system clock edge that takes `mdc` low (or that starts a frame). It stays stable while `mdc` is high. `mdioIn` is sampled on the edge that takes `mdc` high.
- R9: While busy, `mdc` is high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks, so one bit period is 2*`HALF_DIV` clocks. The default of 20 gives 2.5 MHz from 100 MHz.
- R10: A `start` pulse while `busy` is 1 is ignored: the frame in flight is unchanged and no second frame follows.
- R11: `done` is high for exactly one system clock, on the cycle `busy` falls. `rdData` and `rdErr` change only on that cycle of a read frame, and they hold through later write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| isRead | input | 1 | 1 = read, 0 = write |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdData | output | 16 | Data returned by the last read |
| rdErr | output | 1 | Last read saw no low turnaround bit from the PHY |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value for the pad |
| mdioOe | output | 1 | Pad output enable |
| mdioIn | input | 1 | Sampled pad value |

## Verification
The bench decodes every frame bit at the rising management clock, together with the output enable. Its PHY model drives the turnaround zero and the data on reads.

- **Direction confusion:** a design that mixed up the opcodes, dropped a preamble bit or shifted a field would show a wrong captured frame.
- **Late release:** a design that kept driving into the read turnaround would show a wrong enable mask.
- **Missing PHY:** a read with no PHY answering must report the error flag and all-ones data. A design that skipped the turnaround check would return whatever the pull-up produced without flagging it.
- **Start while busy:** a start strobe inside a frame must leave that frame intact and must not launch another.
- **Read data overwritten:** read data must survive a following write. A design that refreshed it on every frame would lose it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;  // first turnaround bit
  localparam int TA_PHY     = TA_FIRST + 1;             // bit the PHY drives low
  localparam int DATA_FIRST = TA_PHY + 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  typedef struct packed {
    logic load;        // capture command, build frame
    logic shift;       // advance transmit shifter (falling mdc)
    logic sampleTa;    // sample PHY turnaround bit (rising mdc)
    logic sampleData;  // sample one read data bit (rising mdc)
    logic commit;      // publish read result
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdioOe,
  output mdioStrobe_t strobe
);
  localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_TA    = BIT_W'(TA_FIRST);
  localparam logic [BIT_W-1:0] BIT_TAPHY = BIT_W'(TA_PHY);
  localparam logic [BIT_W-1:0] BIT_DATA  = BIT_W'(DATA_FIRST);

  logic             busyR, doneR, mdcR, readR;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             tick, riseTick, fallTick, lastBit;

  assign tick     = busyR && (divCnt == DIV_LAST);
  assign riseTick = tick && !mdcR;
  assign fallTick = tick && mdcR;
  assign lastBit  = (bitIdx == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      doneR  <= 1'b0;
      mdcR   <= 1'b0;
      readR  <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else begin
      doneR <= 1'b0;
      if (!busyR) begin
        divCnt <= '0;
        bitIdx <= '0;
        mdcR   <= 1'b0;
        if (start) begin
          busyR <= 1'b1;
          readR <= isRead;
        end
      end else if (tick) begin
        divCnt <= '0;
        if (!mdcR) begin
          mdcR <= 1'b1;
        end else begin
          mdcR <= 1'b0;
          if (lastBit) begin
            busyR <= 1'b0;
            doneR <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load       = !busyR && start;
    strobe.shift      = fallTick && !lastBit;
    strobe.sampleTa   = riseTick && readR && (bitIdx == BIT_TAPHY);
    strobe.sampleData = riseTick && readR && (bitIdx >= BIT_DATA);
    strobe.commit     = fallTick && readR && lastBit;
  end

  assign busy   = busyR;
  assign done   = doneR;
  assign mdc    = mdcR;
  assign mdioOe = busyR && !(readR && (bitIdx >= BIT_TA));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic              isRead,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdErr
);
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;
  logic                  taBad;
  logic [FRAME_BITS-1:0] frameWord;

  assign frameWord = {{PRE_BITS{1'b1}}, START_PAT, (isRead ? OP_READ : OP_WRITE),
                      phyAddr, regAddr, TA_WRITE, wrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      rxShift <= '0;
      taBad   <= 1'b0;
      rdData  <= '0;
      rdErr   <= 1'b0;
    end else begin
      if (strobe.load)
        txShift <= frameWord;
      else if (strobe.shift)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b1};

      if (strobe.load)
        taBad <= 1'b0;
      else if (strobe.sampleTa)
        taBad <= mdioIn;

      if (strobe.sampleData)
        rxShift <= {rxShift[DATA_W-2:0], mdioIn};

      if (strobe.commit) begin
        rdErr  <= taBad;
        rdData <= taBad ? '1 : rxShift;
      end
    end
  end

  assign mdioOut = txShift[FRAME_BITS-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        rdErr,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t strobe;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .busy(busy), .done(done), .mdc(mdc), .mdioOe(mdioOe), .strobe(strobe)
  );

  mdio_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isRead(isRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdData(rdData), .rdErr(rdErr)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic [15:0] rdData,
  input logic        rdErr
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
  a_r9_idle_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  a_r8_out_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(busy));
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(rdData) && $stable(rdErr)) |-> done);
  a_r10_start_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData), .rdErr(rdErr)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 20;
  localparam int NVEC = 5;
  // {isRead, phyAddr, regAddr, wrData, phyReturn}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
    {1'b0, 5'h10, 5'h01, 16'h8001, 16'h0000},
    {1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0001},
    {1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0000}
  };
  localparam logic [63:0] READ_MASK = {{46{1'b1}}, 18'b0};

  logic clk = 0, rstN = 0, start = 0, isRead = 0;
  logic [4:0] phyAddr = 0, regAddr = 0;
  logic [15:0] wrData = 0;
  logic busy, done, rdErr, mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] rdData;

  logic phyEn = 0, phyDrv = 1;
  logic [15:0] phyVal = 0;
  logic [63:0] cap, capOe;
  int riseCnt = 0, cyc = 0, lastRise = -1, badPer = 0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign mdioIn = mdioOe ? mdioOut : (phyEn ? phyDrv : 1'b1);

  mdio_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead), .phyAddr(phyAddr),
    .regAddr(regAddr), .wrData(wrData), .busy(busy), .done(done), .rdData(rdData),
    .rdErr(rdErr), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      cap[63-riseCnt]   = mdioOe ? mdioOut : 1'b0;
      capOe[63-riseCnt] = mdioOe;
    end
    if (lastRise >= 0 && (cyc - lastRise) != 2*HALF) badPer++;
    lastRise = cyc;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if ((cyc - lastRise) != HALF) badPer++;
    if (phyEn && riseCnt >= 47 && riseCnt <= 63)
      phyDrv = (riseCnt == 47) ? 1'b0 : phyVal[63-riseCnt];
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
  endfunction

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin
      errors++;
      $display("FAIL R11 done never seen actual=0 expected=1");
    end
  endtask

  task automatic launch(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] pv, input logic phyOn);
    @(negedge clk);
    riseCnt = 0; lastRise = -1; badPer = 0; cap = '0; capOe = '0;
    phyVal = pv; phyEn = phyOn; phyDrv = 1'b1;
    isRead = rd; phyAddr = pa; regAddr = ra; wrData = wd; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic frameChecks(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd);
    logic [63:0] m;
    logic [63:0] e;
    m = rd ? READ_MASK : '1;
    e = expFrame(rd, pa, ra, wd);
    check(rd ? "R5" : "R4", "enable mask", capOe, m);
    check("R2", "preamble+start", {cap[63:30]}, {32'hFFFF_FFFF, 2'b01});
    check("R3", "opcode+addresses", cap[29:18], e[29:18]);
    if (!rd) check("R4", "turnaround+data", cap[17:0], e[17:0]);
    check("R9", "mdc period errors", badPer, 0);
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {busy, done, mdc, mdioOe, rdErr, rdData},
          {5'b0, 16'h0000});
    rstN = 1;
    repeat (3) @(negedge clk);
    check("R1", "idle after reset", {busy, mdc, mdioOe}, 3'b000);

    // table-driven frames
    for (int v = 0; v < NVEC; v++) begin
      logic rd; logic [4:0] pa, ra; logic [15:0] wd, pv;
      {rd, pa, ra, wd, pv} = VEC[v];
      launch(rd, pa, ra, wd, pv, 1'b1);
      check("R11", "busy after start", busy, 1);
      waitDone(ok);
      check("R11", "busy low at done", busy, 0);
      check("R4", "released at done", mdioOe, 0);
      if (rd) begin
        check("R6", "read data", rdData, pv);
        check("R6", "read error clear", rdErr, 0);
      end
      @(negedge clk);
      check("R11", "done one cycle", done, 0);
      phyEn = 0;
      frameChecks(rd, pa, ra, wd);
    end

    // R7: no PHY answer on read
    launch(1'b1, 5'h03, 5'h02, 16'h0, 16'h1234, 1'b0);
    waitDone(ok);
    check("R7", "error flag", rdErr, 1);
    check("R7", "all-ones data", rdData, 16'hFFFF);
    check("R5", "read enable mask", capOe, READ_MASK);

    // R6 after an error: good read clears flag
    launch(1'b1, 5'h04, 5'h05, 16'h0, 16'h5A0F, 1'b1);
    waitDone(ok);
    phyEn = 0;
    check("R6", "error cleared", rdErr, 0);
    check("R6", "read data after error", rdData, 16'h5A0F);
    held = rdData;

    // R10: start during a frame is ignored
    launch(1'b0, 5'h0C, 5'h11, 16'hBEEF, 16'h0, 1'b0);
    repeat (300) @(negedge clk);
    isRead = 1; phyAddr = 5'h1E; regAddr = 5'h07; wrData = 16'h0F0F; start = 1;
    @(negedge clk);
    start = 0;
    waitDone(ok);
    check("R10", "frame unchanged", cap, expFrame(1'b0, 5'h0C, 5'h11, 16'hBEEF));
    check("R11", "read data held over write", rdData, held);
    check("R11", "read error held over write", rdErr, 0);
    begin
      int busySeen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (busy || mdc) busySeen++;
      end
      check("R10", "no second frame", busySeen, 0);
    end
    check("R11", "read data stable idle", rdData, held);

    // R8 sanity at ports: output not driven when idle
    check("R1", "idle enable", mdioOe, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule